// File: doc/BRIEF.md
# Register Write-Protection Controller

This block guards an 8-bit register file behind a simple synchronous register bus. A dedicated guard register at address 0 holds a mode code, and that code selects one of three protection states. In the locked state only the guard register accepts writes. In the open state every register accepts writes. In the one-shot state exactly one ordinary register write is let through, after which the controller locks itself again. Address 1 is a status register whose bits are set by hardware and cleared by writing ones. A write to it never uses up the one-shot allowance. Addresses 2 and up are plain data registers, and their reserved upper bits always stay zero.

The state machine has three states. LOCKED is the reset state. OPEN is entered by writing the code A5h to the guard register. ONESHOT is entered by writing the code 96h. The transitions are:

- A guard write of any other value moves to LOCKED.
- A guard write jumps to the decoded state from whichever state is current.
- An accepted plain-data write in ONESHOT takes the transition RELOCK back to LOCKED.
- Every other accepted write keeps the current state.

Each accepted write raises one bit of a one-hot write-enable vector in the same cycle. Each refused write raises a one-cycle reject pulse in the following cycle.

Top module: `wprot_ctrl`

## Requirements
- R1: After reset the mode output is 0 (LOCKED), and every address reads 00h. Address 0 reads the canonical code of the current state. The write-enable vector and the reject pulse are low.
- R2: A write to address 0 is accepted in every state. It selects OPEN (mode output 1, readback A5h) for data A5h, and ONESHOT (mode output 2, readback 96h) for data 96h. Any other value selects LOCKED (mode output 0, readback 00h). The new mode shows after the clock edge of the write.
- R3: In LOCKED, a write to any address other than 0 raises no write-enable bit and leaves the addressed register unchanged.
- R4: In OPEN, writes to every address are accepted, and writes to addresses 1 and up leave the state OPEN.
- R5: In ONESHOT, the first write to an address of 2 or higher is accepted, and the state is LOCKED after that clock edge. A further write to a data register is then refused.
- R6: In ONESHOT, a write to the status register at address 1 is accepted and leaves the state ONESHOT, whatever the data.
- R7: When a status write is accepted, each status bit written with 1 is cleared, and each bit written with 0 keeps its value. A status bit whose set input is high in a cycle is 1 after that edge, even if the same cycle clears it.
- R8: Data registers (addresses 2 and up) hold only bits 5:0. Bits 7:6 are never stored and always read 0.
- R9: Read data equals the addressed register whenever the read strobe is high, in every state. It is 00h while the read strobe is low.
- R10: The write-enable vector is one-hot or zero. Its bit for the addressed register is high in the cycle of an accepted write strobe. The reject output is high for exactly the one cycle after a refused write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, combinational |
| stat_set | input | 8 | Hardware set inputs for the status bits |
| reg_we | output | 8 | One-hot write enable per register |
| wr_reject | output | 1 | Pulse in the cycle after a refused write |
| prot_mode | output | 2 | Current state: 0 LOCKED, 1 OPEN, 2 ONESHOT |

## Verification
The bench sweeps all 256 guard codes. A decoder that treated near-miss codes as unlocking would open the file where it must stay shut. A decoder that failed to lock on unknown values would leave the file open.

Every data and status address is written in all three states with several bit patterns. The bench compares each enable, pulse and readback with a model built in the bench. A controller that consumed the one-shot allowance on a status clear would lock too early. One that never relocked would accept a second data write.

Set-versus-clear collisions, zero writes to the status register and the reserved bits are probed directly. Losing a hardware event, clearing on a zero, or storing bits 7:6 would each show up in the readback.

// File: rtl/wprot_pkg.sv
package wprot_pkg;

    typedef enum logic [1:0] {
        ST_LOCKED  = 2'd0,
        ST_OPEN    = 2'd1,
        ST_ONESHOT = 2'd2
    } wprot_state_e;

    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_GUARD = 2'd1,
        ACC_CLEAR = 2'd2,
        ACC_PLAIN = 2'd3
    } wprot_acc_e;

endpackage

// File: rtl/wprot_classify.sv
module wprot_classify
    import wprot_pkg::*;
#(
    parameter int ADDR_W     = 3,
    parameter int GUARD_ADDR = 0,
    parameter int CLEAR_ADDR = 1
) (
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    output wprot_acc_e        kind
);

    always_comb begin
        if (!wr) begin
            kind = ACC_NONE;
        end else if (addr == ADDR_W'(GUARD_ADDR)) begin
            kind = ACC_GUARD;
        end else if (addr == ADDR_W'(CLEAR_ADDR)) begin
            kind = ACC_CLEAR;
        end else begin
            kind = ACC_PLAIN;
        end
    end

endmodule

// File: rtl/wprot_fsm.sv
module wprot_fsm
    import wprot_pkg::*;
#(
    parameter int         DATA_W    = 8,
    parameter logic [7:0] CODE_OPEN = 8'hA5,
    parameter logic [7:0] CODE_ONCE = 8'h96
) (
    input  logic              clk,
    input  logic              rst_n,
    input  wprot_acc_e        kind,
    input  logic [DATA_W-1:0] wdata,
    output wprot_state_e      state,
    output logic              wr_ok,
    output logic              reject
);

    wprot_state_e state_q, state_d;
    logic         reject_q;

    function automatic wprot_state_e decode_code(input logic [DATA_W-1:0] code);
        if (code == DATA_W'(CODE_OPEN)) begin
            return ST_OPEN;
        end else if (code == DATA_W'(CODE_ONCE)) begin
            return ST_ONESHOT;
        end
        return ST_LOCKED;
    endfunction

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_LOCKED;
            reject_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            reject_q <= (kind != ACC_NONE) && !wr_ok;
        end
    end

    // Next state and acceptance
    always_comb begin
        state_d = state_q;
        wr_ok   = 1'b0;
        unique case (state_q)
            ST_LOCKED: begin
                wr_ok = (kind == ACC_GUARD);
            end
            ST_OPEN: begin
                wr_ok = (kind != ACC_NONE);
            end
            ST_ONESHOT: begin
                wr_ok = (kind != ACC_NONE);
                if (kind == ACC_PLAIN) begin
                    state_d = ST_LOCKED;
                end
            end
            default: begin
                state_d = ST_LOCKED;
            end
        endcase
        if (kind == ACC_GUARD) begin
            state_d = decode_code(wdata);
        end
    end

    assign state  = state_q;
    assign reject = reject_q;

endmodule

// File: rtl/wprot_regfile.sv
module wprot_regfile #(
    parameter int         N_REGS     = 8,
    parameter int         DATA_W     = 8,
    parameter int         GUARD_ADDR = 0,
    parameter int         CLEAR_ADDR = 1,
    parameter logic [7:0] RSV_MASK   = 8'hC0
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [N_REGS-1:0]             we,
    input  logic [DATA_W-1:0]             wdata,
    input  logic [DATA_W-1:0]             set_in,
    output logic [N_REGS-1:0][DATA_W-1:0] q
);

    localparam logic [DATA_W-1:0] KEEP = ~DATA_W'(RSV_MASK);

    for (genvar i = 0; i < N_REGS; i++) begin : g_reg
        if (i == GUARD_ADDR) begin : g_guard
            assign q[i] = '0;
        end else if (i == CLEAR_ADDR) begin : g_status
            logic [DATA_W-1:0] r;
            logic [DATA_W-1:0] clr;
            assign clr = we[i] ? wdata : '0;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    r <= '0;
                end else begin
                    r <= (r & ~clr) | set_in;
                end
            end
            assign q[i] = r;
        end else begin : g_data
            logic [DATA_W-1:0] r;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    r <= '0;
                end else if (we[i]) begin
                    r <= wdata & KEEP;
                end
            end
            assign q[i] = r;
        end
    end

endmodule

// File: rtl/wprot_ctrl.sv
module wprot_ctrl
    import wprot_pkg::*;
#(
    parameter int         ADDR_W     = 3,
    parameter int         DATA_W     = 8,
    parameter int         GUARD_ADDR = 0,
    parameter int         CLEAR_ADDR = 1,
    parameter logic [7:0] CODE_OPEN  = 8'hA5,
    parameter logic [7:0] CODE_ONCE  = 8'h96,
    parameter logic [7:0] RSV_MASK   = 8'hC0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic [DATA_W-1:0]      bus_wdata,
    input  logic                   bus_wr,
    input  logic                   bus_rd,
    output logic [DATA_W-1:0]      bus_rdata,
    input  logic [DATA_W-1:0]      stat_set,
    output logic [(1<<ADDR_W)-1:0] reg_we,
    output logic                   wr_reject,
    output logic [1:0]             prot_mode
);

    localparam int N_REGS = 1 << ADDR_W;

    wprot_acc_e                   kind;
    wprot_state_e                 state;
    logic                         wr_ok;
    logic [N_REGS-1:0][DATA_W-1:0] regs_q;
    logic [DATA_W-1:0]            guard_view;

    wprot_classify #(
        .ADDR_W    (ADDR_W),
        .GUARD_ADDR(GUARD_ADDR),
        .CLEAR_ADDR(CLEAR_ADDR)
    ) u_classify (
        .wr  (bus_wr),
        .addr(bus_addr),
        .kind(kind)
    );

    wprot_fsm #(
        .DATA_W   (DATA_W),
        .CODE_OPEN(CODE_OPEN),
        .CODE_ONCE(CODE_ONCE)
    ) u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .kind  (kind),
        .wdata (bus_wdata),
        .state (state),
        .wr_ok (wr_ok),
        .reject(wr_reject)
    );

    for (genvar i = 0; i < N_REGS; i++) begin : g_we
        assign reg_we[i] = wr_ok && (bus_addr == ADDR_W'(i));
    end

    wprot_regfile #(
        .N_REGS    (N_REGS),
        .DATA_W    (DATA_W),
        .GUARD_ADDR(GUARD_ADDR),
        .CLEAR_ADDR(CLEAR_ADDR),
        .RSV_MASK  (RSV_MASK)
    ) u_regfile (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (reg_we),
        .wdata (bus_wdata),
        .set_in(stat_set),
        .q     (regs_q)
    );

    // Output process: canonical guard code and read mux
    always_comb begin
        unique case (state)
            ST_OPEN:    guard_view = DATA_W'(CODE_OPEN);
            ST_ONESHOT: guard_view = DATA_W'(CODE_ONCE);
            default:    guard_view = '0;
        endcase
        if (!bus_rd) begin
            bus_rdata = '0;
        end else if (bus_addr == ADDR_W'(GUARD_ADDR)) begin
            bus_rdata = guard_view;
        end else begin
            bus_rdata = regs_q[bus_addr];
        end
    end

    assign prot_mode = state;

endmodule

// File: rtl/wprot_checker.sv
module wprot_checker #(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [ADDR_W-1:0]      bus_addr,
    input logic                   bus_wr,
    input logic                   bus_rd,
    input logic [DATA_W-1:0]      bus_rdata,
    input logic [(1<<ADDR_W)-1:0] reg_we,
    input logic                   wr_reject,
    input logic [1:0]             prot_mode
);

    a_r3_locked_no_we: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_mode == 2'd0 && bus_wr && bus_addr != '0) |-> (reg_we == '0));

    a_r4_open_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_mode == 2'd1 && bus_wr && bus_addr != '0) |=> (prot_mode == 2'd1));

    a_r5_oneshot_relock: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_mode == 2'd2 && bus_wr && bus_addr >= ADDR_W'(2)) |=> (prot_mode == 2'd0));

    a_r6_clear_keeps_oneshot: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_mode == 2'd2 && bus_wr && bus_addr == ADDR_W'(1)) |=> (prot_mode == 2'd2));

    a_r9_idle_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> (bus_rdata == '0));

    a_r10_we_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(reg_we));

    a_r10_reject_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && reg_we == '0) |=> wr_reject);

    a_r10_reject_cause: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> !wr_reject);

    a_r2_mode_legal: assert property (@(posedge clk) disable iff (!rst_n)
        prot_mode != 2'd3);

endmodule

bind wprot_ctrl wprot_checker #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
) u_wprot_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_rdata(bus_rdata),
    .reg_we   (reg_we),
    .wr_reject(wr_reject),
    .prot_mode(prot_mode)
);

// File: tb/test_wprot_ctrl.sv
module test_wprot_ctrl;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_rdata;
    logic [7:0] stat_set = '0;
    logic [7:0] reg_we;
    logic       wr_reject;
    logic [1:0] prot_mode;

    int checks = 0;
    int errors = 0;

    // bench model
    logic [7:0] m_reg [8];
    int         m_mode = 0;

    wprot_ctrl i_wprot_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .bus_rdata(bus_rdata),
        .stat_set (stat_set),
        .reg_we   (reg_we),
        .wr_reject(wr_reject),
        .prot_mode(prot_mode)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] code_of(input int md);
        if (md == 1) return 8'hA5;
        if (md == 2) return 8'h96;
        return 8'h00;
    endfunction

    // write with optional simultaneous status set
    task automatic bus_write(input int a, input logic [7:0] d, input logic [7:0] s, input string req);
        bit ok;
        @(negedge clk);
        bus_addr = 3'(a); bus_wdata = d; bus_wr = 1'b1; stat_set = s;
        ok = (a == 0) || (m_mode != 0);
        #1;
        check({req, " reg_we"}, int'(reg_we), ok ? (1 << a) : 0);
        @(posedge clk);
        if (ok) begin
            if (a == 0) begin
                m_mode = (d == 8'hA5) ? 1 : (d == 8'h96) ? 2 : 0;
            end else if (a == 1) begin
                m_reg[1] = m_reg[1] & ~d;
            end else begin
                m_reg[a] = d & 8'h3F;
                if (m_mode == 2) m_mode = 0;
            end
        end
        m_reg[1] = m_reg[1] | s;
        @(negedge clk);
        bus_wr = 1'b0; stat_set = '0;
        #1;
        check({req, " wr_reject"}, int'(wr_reject), ok ? 0 : 1);
        check({req, " prot_mode"}, int'(prot_mode), m_mode);
    endtask

    task automatic bus_read(input int a, input string req);
        @(negedge clk);
        bus_addr = 3'(a); bus_rd = 1'b1;
        #1;
        check({req, " rdata"}, int'(bus_rdata), (a == 0) ? int'(code_of(m_mode)) : int'(m_reg[a]));
        check("R10 reject low when idle", int'(wr_reject), 0);
        bus_rd = 1'b0;
        #1;
        check("R9 rdata zero without strobe", int'(bus_rdata), 0);
    endtask

    task automatic pulse_set(input logic [7:0] s);
        @(negedge clk);
        stat_set = s;
        @(posedge clk);
        m_reg[1] = m_reg[1] | s;
        @(negedge clk);
        stat_set = '0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] pats [4] = '{8'hFF, 8'h55, 8'hAA, 8'h00};
        for (int i = 0; i < 8; i++) m_reg[i] = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        #1;
        check("R1 mode after reset", int'(prot_mode), 0);
        check("R1 reg_we after reset", int'(reg_we), 0);
        check("R1 reject after reset", int'(wr_reject), 0);
        for (int a = 0; a < 8; a++) bus_read(a, "R1 reset value");

        // R2 full code sweep
        for (int c = 0; c < 256; c++) begin
            bus_write(0, 8'(c), 8'h00, "R2 code sweep");
            bus_read(0, "R2 canonical readback");
            bus_write(0, 8'h00, 8'h00, "R2 relock");
        end

        // R3 R4 R5 R8: every mode, every address, several patterns
        for (int md = 0; md < 3; md++) begin
            for (int a = 1; a < 8; a++) begin
                foreach (pats[p]) begin
                    pulse_set(8'hFF);
                    bus_write(0, code_of(md), 8'h00, "R2 mode select");
                    bus_write(a, pats[p] ^ 8'(a), 8'h00,
                              (md == 0) ? "R3 locked write" : (md == 1) ? "R4 open write" : "R5 oneshot write");
                    bus_read(a, "R8 stored value");
                    if (md == 1) check("R4 open persists", int'(prot_mode), 1);
                    if (md == 2 && a >= 2) begin
                        bus_write(a, 8'h3C, 8'h00, "R5 second write refused");
                        bus_read(a, "R5 value unchanged");
                    end
                end
            end
        end

        // R6 R7: status clears in oneshot do not consume the allowance
        bus_write(0, 8'h96, 8'h00, "R6 enter oneshot");
        pulse_set(8'hFF);
        bus_write(1, 8'h0F, 8'h00, "R6 clear low nibble");
        bus_read(1, "R7 partial clear");
        bus_write(1, 8'h00, 8'h00, "R7 zero write no effect");
        bus_read(1, "R7 zero write keeps bits");
        check("R6 still oneshot", int'(prot_mode), 2);
        bus_write(5, 8'hFF, 8'h00, "R5 consume after clears");
        bus_read(5, "R8 reserved bits masked");
        bus_write(6, 8'h11, 8'h00, "R5 locked after consume");

        // R7 set wins over clear in the same cycle
        bus_write(0, 8'hA5, 8'h00, "R7 open");
        bus_write(1, 8'hFF, 8'h81, "R7 set versus clear");
        bus_read(1, "R7 set wins");
        bus_write(1, 8'hFF, 8'h00, "R7 clear all");
        bus_read(1, "R7 all cleared");

        // R9 reads in locked state
        bus_write(0, 8'h00, 8'h00, "R9 lock");
        for (int a = 0; a < 8; a++) bus_read(a, "R9 read while locked");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule